// File: doc/BRIEF.md
# Group Activation Precision Detector

This block looks at a group of activations that a bit-serial datapath will consume together and reports the fewest bits that hold every value in the group. It builds a presence vector in which each bit marks a bit position occupied by at least one activation of the group. A leading-one search on that vector gives the needed width. The result is then limited by the width that profiling fixed for the current layer. It is also rounded up to the number of activation bits the datapath consumes per cycle.

A group arrives over several beats on a wide parallel bus with a valid/ready handshake. Each beat carries `LANES` activations of `AW` bits. The beat that opens a group carries a first flag, and the beat that closes it carries a last flag. The block applies no back-pressure: `in_ready` is high whenever reset is released, so every beat with `in_valid` high is taken on that edge. One cycle after the closing beat is taken, the block raises `out_valid` for exactly one cycle. `out_prec` then holds the group's width until the next result replaces it.

Top module: `act_prec_detect`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it, `out_valid` and `out_prec` read 0. `in_ready` is low during reset.
- R2: The result before limiting is one more than the highest bit position that is 1 in any activation of any accepted beat of the group. Lane `l` occupies bits `l*AW+AW-1` down to `l*AW` of `in_data`, and bit 0 of each lane is its least significant bit.
- R3: An accepted beat with `in_first` high discards everything gathered from earlier groups, so only that beat and the ones after it count.
- R4: Data presented while `in_valid` is low has no effect on the result.
- R5: A group whose activations are all zero yields 1 before limiting and rounding, never 0.
- R6: The width before rounding is the smaller of the detected value and the layer ceiling `layer_prec`, sampled on the closing beat. A ceiling of 0 acts as 1, and a ceiling above `AW` acts as `AW`.
- R7: The limited width is rounded up to the next multiple of `STEP`, the per-cycle bit count, which is a power of two that divides `AW`.
- R8: `out_valid` is high for one cycle, exactly one cycle after an accepted beat with `in_last` high. `out_prec` changes only at that point.
- R9: `in_ready` is high in every cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Beat present on `in_data` |
| in_ready | output | 1 | Beat accepted when high together with `in_valid` |
| in_first | input | 1 | Beat opens a new group |
| in_last | input | 1 | Beat closes the group |
| in_data | input | LANES*AW | Packed activations of one beat |
| layer_prec | input | $clog2(AW+1) | Layer width ceiling |
| out_valid | output | 1 | One-cycle result strobe |
| out_prec | output | $clog2(AW+1) | Group width in bits |

## Verification
A wrong bit left in the presence accumulator shows up as a width that is too large. It appears on the very next `out_valid` strobe of a group whose real width is smaller, which is why the bench follows wide groups with narrow ones. Faults in the limit or the rounding appear as widths above the ceiling or off a `STEP` boundary on the same strobe. A timing fault in the result register shows up as a strobe a cycle early, a cycle late, or lasting two cycles. It also shows up as `out_prec` moving between strobes, and both are sampled in the cycle after each group closes.

// File: rtl/act_prec_pkg.sv
package act_prec_pkg;
  // width of a bit-count field able to hold 0..w
  function automatic int count_width(int w);
    return $clog2(w + 1);
  endfunction
endpackage

// File: rtl/act_prec_lane_or.sv
module act_prec_lane_or #(
  parameter int LANES = 16,
  parameter int AW    = 16
) (
  input  logic [LANES*AW-1:0] lanes,
  output logic [AW-1:0]       presence
);
  genvar b, l;
  generate
    for (b = 0; b < AW; b++) begin : g_bit
      logic [LANES-1:0] column;
      for (l = 0; l < LANES; l++) begin : g_lane
        assign column[l] = lanes[l*AW + b];
      end
      assign presence[b] = |column;
    end
  endgenerate
endmodule

// File: rtl/act_prec_lod.sv
module act_prec_lod #(
  parameter int AW = 16,
  parameter int PW = 5
) (
  input  logic [AW-1:0] vec,
  output logic [PW-1:0] width
);
  always_comb begin
    width = '0;
    for (int i = 0; i < AW; i++) begin
      if (vec[i]) width = PW'(i + 1);
    end
  end
endmodule

// File: rtl/act_prec_shape.sv
module act_prec_shape #(
  parameter int AW   = 16,
  parameter int PW   = 5,
  parameter int STEP = 1
) (
  input  logic [PW-1:0] raw,
  input  logic [PW-1:0] ceiling,
  output logic [PW-1:0] prec
);
  logic [PW-1:0] floor_raw, cap, lim;

  always_comb begin
    floor_raw = (raw == '0) ? PW'(1) : raw;
    if (ceiling == '0)           cap = PW'(1);
    else if (ceiling > PW'(AW))  cap = PW'(AW);
    else                         cap = ceiling;
    lim = (floor_raw < cap) ? floor_raw : cap;
  end

  generate
    if (STEP > 1) begin : g_round
      logic [PW:0] sum;
      assign sum  = {1'b0, lim} + (PW+1)'(STEP - 1);
      assign prec = PW'(sum & ~((PW+1)'(STEP - 1)));
    end else begin : g_pass
      assign prec = lim;
    end
  endgenerate
endmodule

// File: rtl/act_prec_detect.sv
module act_prec_detect
  import act_prec_pkg::*;
#(
  parameter int LANES = 16,
  parameter int AW    = 16,
  parameter int STEP  = 1,
  localparam int PW   = count_width(AW)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_first,
  input  logic                in_last,
  input  logic [LANES*AW-1:0] in_data,
  input  logic [PW-1:0]       layer_prec,
  output logic                out_valid,
  output logic [PW-1:0]       out_prec
);
  logic          take;
  logic [AW-1:0] beat_bits, acc_q, acc_d;
  logic [PW-1:0] raw_w, shaped;

  assign in_ready = rst_n;
  assign take     = in_valid && in_ready;

  act_prec_lane_or #(.LANES(LANES), .AW(AW)) u_or (
    .lanes(in_data), .presence(beat_bits));

  assign acc_d = (in_first ? '0 : acc_q) | beat_bits;

  act_prec_lod #(.AW(AW), .PW(PW)) u_lod (.vec(acc_d), .width(raw_w));

  act_prec_shape #(.AW(AW), .PW(PW), .STEP(STEP)) u_shape (
    .raw(raw_w), .ceiling(layer_prec), .prec(shaped));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      out_valid <= 1'b0;
      out_prec  <= '0;
    end else begin
      out_valid <= take && in_last;
      if (take) acc_q <= acc_d;
      if (take && in_last) out_prec <= shaped;
    end
  end

  // R8
  strobe_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_ready && in_last));
  // R8
  prec_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready && in_last) |=> $stable(out_prec));
  // R5
  prec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_prec >= PW'(1)) && (out_prec <= PW'(AW)));
  // R7
  step_multiple_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_prec) % STEP) == 0);
  // R6
  ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last && layer_prec == PW'(1)) |=> out_prec == PW'(STEP));
endmodule

// File: tb/act_prec_detect_bench.sv
module act_prec_detect_bench;
  localparam int LANES = 16;
  localparam int AW    = 16;
  localparam int PW    = $clog2(AW + 1);

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                in_valid = 1'b0;
  logic                in_first = 1'b0;
  logic                in_last = 1'b0;
  logic [LANES*AW-1:0] in_data = '0;
  logic [PW-1:0]       layer_prec = '0;
  logic                rdy1, rdy4, ov1, ov4;
  logic [PW-1:0]       op1, op4;

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] grp_or = '0;

  always #2.5 clk = ~clk;

  act_prec_detect #(.LANES(LANES), .AW(AW), .STEP(1)) u_act_prec_detect (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy1),
    .in_first(in_first), .in_last(in_last), .in_data(in_data),
    .layer_prec(layer_prec), .out_valid(ov1), .out_prec(op1));

  act_prec_detect #(.LANES(LANES), .AW(AW), .STEP(4)) u_act_prec_detect_s4 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy4),
    .in_first(in_first), .in_last(in_last), .in_data(in_data),
    .layer_prec(layer_prec), .out_valid(ov4), .out_prec(op4));

  function automatic int expect_prec(logic [AW-1:0] bits, int layer, int step);
    int w, cap, m;
    w = 0;
    for (int i = 0; i < AW; i++) if (bits[i]) w = i + 1;
    if (w == 0) w = 1;
    cap = (layer == 0) ? 1 : ((layer > AW) ? AW : layer);
    m = (w < cap) ? w : cap;
    return ((m + step - 1) / step) * step;
  endfunction

  function automatic logic [AW-1:0] fold(logic [LANES*AW-1:0] d);
    logic [AW-1:0] r;
    r = '0;
    for (int l = 0; l < LANES; l++) r = r | d[l*AW +: AW];
    return r;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic beat(logic [LANES*AW-1:0] d, logic first, logic last, int layer);
    @(negedge clk);
    in_valid = 1'b1; in_first = first; in_last = last; in_data = d;
    layer_prec = PW'(layer);
    grp_or = (first ? '0 : grp_or) | fold(d);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b1;
    in_data = '1;
  endtask

  task automatic close_group(string req, int layer);
    int e1, e4, p1, p4;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_first = 1'b0;
    e1 = expect_prec(grp_or, layer, 1);
    e4 = expect_prec(grp_or, layer, 4);
    chk({req, " strobe R8"}, int'(ov1), 1);
    chk({req, " width step1"}, int'(op1), e1);
    chk({req, " strobe4 R8"}, int'(ov4), 1);
    chk({req, " width step4 R7"}, int'(op4), e4);
    p1 = int'(op1); p4 = int'(op4);
    @(negedge clk);
    chk("R8 single pulse", int'(ov1) + int'(ov4), 0);
    chk("R8 held", int'(op1), p1);
    chk("R8 held4", int'(op4), p4);
  endtask

  function automatic logic [LANES*AW-1:0] one_lane(int lane, logic [AW-1:0] v);
    logic [LANES*AW-1:0] d;
    d = '0;
    d[lane*AW +: AW] = v;
    return d;
  endfunction

  function automatic logic [LANES*AW-1:0] rand_beat();
    logic [LANES*AW-1:0] d;
    int w;
    logic [31:0] mask;
    w = $urandom_range(0, AW);
    mask = (32'h1 << w) - 32'h1;
    for (int l = 0; l < LANES; l++) d[l*AW +: AW] = AW'($urandom & mask);
    return d;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset strobe", int'(ov1) + int'(ov4), 0);
    chk("R1 reset width", int'(op1) + int'(op4), 0);
    chk("R1 reset ready", int'(rdy1), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset strobe", int'(ov1), 0);
    chk("R1 after reset width", int'(op1), 0);
    chk("R9 ready", int'(rdy1) & int'(rdy4), 1);

    // R5 all-zero group
    beat('0, 1'b1, 1'b1, 16); close_group("R5 zero", 16);
    // R2 top bit in one lane
    beat(one_lane(7, 16'h8000), 1'b1, 1'b1, 16); close_group("R2 msb", 16);
    // R2 multi-beat gather
    beat(one_lane(3, 16'h0010), 1'b1, 1'b0, 16);
    beat(one_lane(12, 16'h0003), 1'b0, 1'b1, 16); close_group("R2 beats", 16);
    // R6 ceiling, R7 rounding after ceiling
    beat(one_lane(0, 16'hFFFF), 1'b1, 1'b1, 9); close_group("R6 cap9", 9);
    // R3 first flag clears
    beat(one_lane(15, 16'h8000), 1'b1, 1'b1, 16); close_group("R3 wide", 16);
    beat(one_lane(15, 16'h0001), 1'b1, 1'b1, 16); close_group("R3 narrow", 16);
    // R4 idle garbage ignored
    beat(one_lane(2, 16'h0001), 1'b1, 1'b0, 16);
    idle();
    beat(one_lane(9, 16'h0002), 1'b0, 1'b1, 16); close_group("R4 idle", 16);
    // R6 ceiling of 0 and above AW
    beat(one_lane(5, 16'h0F00), 1'b1, 1'b1, 0); close_group("R6 cap0", 0);
    beat(one_lane(5, 16'hFFFF), 1'b1, 1'b1, 20); close_group("R6 cap20", 20);

    // random groups: R2 R6 R7
    for (int g = 0; g < 60; g++) begin
      int nb, layer;
      nb = $urandom_range(1, 4);
      layer = $urandom_range(0, 20);
      for (int b = 0; b < nb; b++) begin
        if (b > 0 && $urandom_range(0, 3) == 0) idle();
        beat(rand_beat(), b == 0, b == nb - 1, layer);
      end
      close_group("R2 random", layer);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule